// File: doc/BRIEF.md
# Self-Correcting Six-State Sequence Counter

This block is a three-bit synchronous counter that walks a fixed loop of six codes. The two low bits step through 00, 01, 10 and then wrap. The top bit flips each time those two low bits wrap, so it stays at one value for three steps and then changes. The codes 011 and 111 are not part of the loop. Each of the three bits is a JK-style storage cell. The J and K inputs of each cell come from fixed equations on the present state, so the next state is the same for every code, and the two unused codes lead back into the loop after one step.

The counter advances only on clock edges where the enable is high. A synchronous reset has the highest priority and returns the counter to 000. A synchronous load has the next priority: it places any three-bit value in the counter, including the two unused codes. The load lets the surrounding logic, or a bench, start the counter at a chosen state. All pins are plain control or status pins; the block has no streaming interface.

Top module: `six_seq_counter`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `state_o` is 000 after that edge, whatever `load_i` and `en_i` are.
- R2: When `rst_i` is low and `load_i` is high at a rising edge, `state_o` takes the value of `load_val_i` after that edge, whatever `en_i` is.
- R3: When `rst_i`, `load_i` and `en_i` are all low at a rising edge, `state_o` keeps its value. This applies to the unused codes 011 and 111 as well.
- R4: On enabled edges, where `en_i` is high and both `rst_i` and `load_i` are low, the legal codes follow the loop 000, 001, 010, 100, 101, 110 and then back to 000.
- R5: On enabled steps, bits [1:0] go 00 to 01 to 10 and back to 00. Bit [2] inverts exactly on the step where bits [1:0] go from 10 to 00, and holds on every other step.
- R6: An enabled step from the unused code 011 gives 100.
- R7: An enabled step from the unused code 111 gives 000.
- R8: After any enabled step, `state_o` is never 011 or 111.
- R9: Each bit follows a JK update: 00 holds, 01 clears, 10 sets and 11 inverts. The inputs are J2=K2=bit1, J1=bit0, K1=1, J0=NOT bit1 and K0=1. R4, R6 and R7 are the results of these equations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset to 000, active high |
| en_i | input | 1 | Advance one step on this edge |
| load_i | input | 1 | Synchronous load of `load_val_i` |
| load_val_i | input | 3 | Value to load; bit 2 is the top bit |
| state_o | output | 3 | Present state; bit 2 is the top bit |

## Verification
A run from reset with the enable held high for more than two full loops checks the order of the codes. The same run checks the three-step rhythm of the top bit, and it shows up any step that is swapped or skipped. Loading 011 and 111 and then taking one enabled step shows that each unused code has its own recovery target, and a further step shows that the counter then continues along the loop. A fixed, irregular enable pattern separates holding from stepping. Loads made with the enable high, and resets made with the load active, show the priority order among the three controls.

// File: rtl/six_seq_pkg.sv
package six_seq_pkg;
  localparam int unsigned SEQ_W = 3;
  localparam int unsigned BIT_A = SEQ_W - 1;
  localparam int unsigned BIT_B = SEQ_W - 2;
  localparam int unsigned BIT_C = SEQ_W - 3;

  typedef logic [SEQ_W-1:0] seq_t;

  localparam seq_t HOME   = 3'b000;
  localparam seq_t GAP_LO = 3'b011;
  localparam seq_t GAP_HI = 3'b111;

  typedef enum logic [1:0] {
    JK_HOLD = 2'b00,
    JK_CLR  = 2'b01,
    JK_SET  = 2'b10,
    JK_FLIP = 2'b11
  } jk_op_e;
endpackage

// File: rtl/six_seq_excite.sv
module six_seq_excite
  import six_seq_pkg::*;
(
  input  seq_t cur_i,
  output seq_t j_o,
  output seq_t k_o
);
  // Fixed excitation equations; the unused codes fall back into the loop (R9)
  always_comb begin
    j_o        = '0;
    k_o        = '0;
    j_o[BIT_A] = cur_i[BIT_B];
    k_o[BIT_A] = cur_i[BIT_B];
    j_o[BIT_B] = cur_i[BIT_C];
    k_o[BIT_B] = 1'b1;
    j_o[BIT_C] = ~cur_i[BIT_B];
    k_o[BIT_C] = 1'b1;
  end
endmodule

// File: rtl/six_seq_jk_bit.sv
module six_seq_jk_bit
  import six_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic load_d_i,
  input  logic step_i,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  jk_op_e op;
  logic   nxt;

  always_comb begin
    op = jk_op_e'({j_i, k_i});
    unique case (op)
      JK_HOLD: nxt = q_o;
      JK_CLR:  nxt = 1'b0;
      JK_SET:  nxt = 1'b1;
      JK_FLIP: nxt = ~q_o;
      default: nxt = q_o;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       q_o <= 1'b0;
    else if (load_i) q_o <= load_d_i;
    else if (step_i) q_o <= nxt;
  end
endmodule

// File: rtl/six_seq_counter.sv
module six_seq_counter
  import six_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SEQ_W-1:0] load_val_i,
  output logic [SEQ_W-1:0] state_o
);
  seq_t j_vec;
  seq_t k_vec;
  seq_t q_vec;

  six_seq_excite u_excite (
    .cur_i (q_vec),
    .j_o   (j_vec),
    .k_o   (k_vec)
  );

  for (genvar g = 0; g < SEQ_W; g++) begin : g_bit
    six_seq_jk_bit u_cell (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load_i),
      .load_d_i (load_val_i[g]),
      .step_i   (en_i),
      .j_i      (j_vec[g]),
      .k_i      (k_vec[g]),
      .q_o      (q_vec[g])
    );
  end

  assign state_o = q_vec;

  // ---------------- assertions ----------------
  logic rst_d;
  always_ff @(posedge clk_i) begin
    rst_d <= rst_i;
    if (rst_d) begin
      AST_RESET_CLEARS: assert (state_o == HOME); // R1
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (state_o == $past(load_val_i))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !load_i) |=> $stable(state_o)); // R3

  AST_LOW_PAIR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !load_i && state_o[1:0] == 2'b00) |=> (state_o[1:0] == 2'b01 && $stable(state_o[2]))); // R5

  AST_TOP_FLIPS_ON_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !load_i && state_o[1:0] == 2'b10) |=> (state_o[1:0] == 2'b00 && state_o[2] != $past(state_o[2]))); // R5

  AST_GAP_LO_RECOVERS: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !load_i && state_o == GAP_LO) |=> (state_o == 3'b100)); // R6

  AST_GAP_HI_RECOVERS: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !load_i && state_o == GAP_HI) |=> (state_o == HOME)); // R7

  AST_NO_GAP_AFTER_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !load_i) |=> (state_o != GAP_LO && state_o != GAP_HI)); // R8
endmodule

// File: tb/test_six_seq_counter.sv
module test_six_seq_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [2:0] load_val_i = 3'b000;
  logic [2:0] state_o;

  int n_checks = 0;
  int n_fail = 0;

  six_seq_counter i_six_seq_counter (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .state_o    (state_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Expected successor from the requirement tables (R4, R6, R7)
  function automatic logic [2:0] succ(input logic [2:0] s);
    case (s)
      3'b000: succ = 3'b001;
      3'b001: succ = 3'b010;
      3'b010: succ = 3'b100;
      3'b100: succ = 3'b101;
      3'b101: succ = 3'b110;
      3'b110: succ = 3'b000;
      3'b011: succ = 3'b100;
      default: succ = 3'b000;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    n_checks++;
    if (state_o !== exp) begin
      n_fail++;
      $display("FAIL %s: state_o=%b expected %b", req, state_o, exp);
    end
  endtask

  task automatic t_reset();
    rst_i = 1'b1; en_i = 1'b0; load_i = 1'b0;
    tick(); tick();
    check("R1 reset state", 3'b000);
    rst_i = 1'b0;
  endtask

  task automatic t_main_loop();
    logic [2:0] exp;
    t_reset();
    exp = 3'b000;
    en_i = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      tick();
      exp = succ(exp);
      check("R4 loop order", exp);
      // R5: low pair counts i mod 3, top bit flips every three steps
      check("R5 bit rhythm", {1'((i / 3) % 2), 2'(i % 3)});
      check("R8 no unused code", (state_o == 3'b011 || state_o == 3'b111) ? ~state_o : state_o);
    end
    en_i = 1'b0;
  endtask

  task automatic t_hold();
    t_reset();
    en_i = 1'b1;
    tick(); tick();
    en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 hold with enable low", 3'b010);
    end
  endtask

  task automatic t_recover(input logic [2:0] gap, input logic [2:0] target, input string req);
    load_i = 1'b1; load_val_i = gap; en_i = 1'b0;
    tick();
    check("R2 load unused code", gap);
    load_i = 1'b0;
    tick();
    check("R3 unused code held", gap);
    en_i = 1'b1;
    tick();
    check(req, target);
    tick();
    check("R4 loop resumes", succ(target));
    en_i = 1'b0;
  endtask

  task automatic t_load_priority();
    load_i = 1'b1; en_i = 1'b1; load_val_i = 3'b101;
    tick();
    check("R2 load beats enable", 3'b101);
    load_val_i = 3'b010;
    tick();
    check("R2 second load", 3'b010);
    load_i = 1'b0; en_i = 1'b0;
  endtask

  task automatic t_reset_priority();
    load_i = 1'b1; en_i = 1'b1; load_val_i = 3'b110;
    rst_i = 1'b1;
    tick();
    check("R1 reset beats load", 3'b000);
    rst_i = 1'b0; load_i = 1'b0; en_i = 1'b0;
  endtask

  task automatic t_enable_pattern();
    logic [15:0] pat;
    logic [2:0]  exp;
    pat = 16'hB5C3;
    t_reset();
    exp = 3'b000;
    for (int i = 0; i < 16; i++) begin
      en_i = pat[i];
      tick();
      if (pat[i]) exp = succ(exp);
      check("R9 stepping under mixed enable", exp);
    end
    en_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog (R1..R9 run): state_o=%b expected run to finish", state_o);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_main_loop();
    t_hold();
    t_recover(3'b011, 3'b100, "R6 recovery from 011");
    t_recover(3'b111, 3'b000, "R7 recovery from 111");
    t_load_priority();
    t_reset_priority();
    t_enable_pattern();
    summary();
    $finish;
  end
endmodule